// File: doc/BRIEF.md
# Rotating Ones-Complement Word Checksum

This block computes a software checksum over a stream of data words, one word per clock. Each word is folded into a running accumulator with ones-complement addition: the carry out of the top bit is added back in at bit 0. After every addition the accumulator is rotated left by one bit. A start marker restarts the accumulator at zero, and that word is the first one in the sum. An end marker closes the packet. One cycle later the block presents the final checksum, a one-cycle done pulse and a comparison against the checksum carried in the packet.

Two conventions apply at the end of a packet. A final sum of all ones is reported as zero. A carried checksum of all ones means the sender did not compute a checksum, so the compare is switched off for that packet. The caller decides which packet words are fed in. Normally these are the words after the checksum word, up to the last word before the hardware CRC.

A parameter selects how each step is computed: add then rotate, or rotate both operands then add. The two give the same value. A second parameter can turn off the folding of all ones to zero.

Top module: `rotsum_engine`

## Requirements
- R1: The accumulator starts from zero on a word with the start marker set, so that word is the first term. After an end-marker word the next packet also starts from zero, even with no start marker.
- R2: Each accepted word is added with ones-complement arithmetic: a carry out of bit W-1 is added back into bit 0. For example, words 0x8000 then 0xFFFF give 0x0002.
- R3: After each addition the accumulator is rotated left by one bit: bit W-1 moves to bit 0. A single word 0x0001 gives 0x0002.
- R4: Both step orderings (ORDER add-then-rotate, and rotate-both-then-add) give identical results for every stream.
- R5: With FOLD_ALLONES=1 a final sum of all ones (0xFFFF) is reported as 0x0000. With FOLD_ALLONES=0 it is reported as 0xFFFF. Words 0x0001 then 0xFFFD sum to all ones.
- R6: check_en_o is low for a packet whose expect_i, sampled with the end-marker word, is all ones. Otherwise it is high.
- R7: match_o is high exactly when check_en_o is high and sum_o equals the sampled expect_i.
- R8: done_o pulses high for one cycle, in the cycle after an accepted end-marker word. sum_o, match_o and check_en_o change only when done_o rises, and they hold otherwise.
- R9: clr_i high restarts the accumulator at zero. Any word offered in the same cycle is dropped, including an end-marker word, which then raises no done_o.
- R10: One word is accepted per clock while word_vld_i is high. Cycles with word_vld_i low leave the accumulator unchanged, whatever word_i carries.
- R11: After reset sum_o, done_o, match_o and check_en_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous restart of accumulation, wins over a word |
| word_vld_i | input | 1 | A word is offered this cycle |
| word_sop_i | input | 1 | Offered word is the first of a packet |
| word_eop_i | input | 1 | Offered word is the last of a packet |
| word_i | input | W | Data word |
| expect_i | input | W | Checksum carried in the packet, sampled with the end-marker word |
| sum_o | output | W | Final checksum of the last packet |
| done_o | output | 1 | One-cycle pulse: a new result is present |
| match_o | output | 1 | Result equals the carried checksum, with checking enabled |
| check_en_o | output | 1 | Carried checksum was not the all-ones sentinel |

## Verification
The bench builds two copies side by side at W=16 and feeds them the same stimulus. One uses add-then-rotate with folding on. The other uses rotate-then-add with folding off. Because of this pairing, a single stream whose sum reaches all ones shows both the folded zero and the raw all-ones value in the same cycle. The pairing also compares the two step orderings on every packet, including end-around carries, clears in the middle of a packet and gaps in the valid signal.

// File: rtl/rotsum_pkg.sv
package rotsum_pkg;

   // Ordering of the per-word step; both produce the same value.
   typedef enum logic {
      ORD_ADD_ROT = 1'b0,  // add word, then rotate accumulator
      ORD_ROT_ADD = 1'b1   // rotate both operands, then add
   } order_e;

   // Per-cycle stream control
   typedef struct packed {
      logic clr;
      logic vld;
      logic sop;
      logic eop;
   } ctl_t;

endpackage

// File: rtl/rotsum_ocadd.sv
module rotsum_ocadd #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);

   localparam int SW = W + 1;

   logic [SW-1:0] raw;

   always_comb begin
      raw = {1'b0, a_i} + {1'b0, b_i};
      // end-around carry; the second add can never carry out again
      y_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
   end

endmodule

// File: rtl/rotsum_step.sv
module rotsum_step #(
   parameter int               W     = 16,
   parameter rotsum_pkg::order_e ORDER = rotsum_pkg::ORD_ADD_ROT
) (
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] nxt_o
);

   localparam int TOP = W - 1;

   generate
      if (ORDER == rotsum_pkg::ORD_ADD_ROT) begin : g_add_rot
         logic [W-1:0] sum;
         rotsum_ocadd #(.W(W)) u_add (
            .a_i (acc_i),
            .b_i (word_i),
            .y_o (sum)
         );
         assign nxt_o = {sum[TOP-1:0], sum[TOP]};
      end else begin : g_rot_add
         logic [W-1:0] acc_r;
         logic [W-1:0] word_r;
         assign acc_r  = {acc_i[TOP-1:0],  acc_i[TOP]};
         assign word_r = {word_i[TOP-1:0], word_i[TOP]};
         rotsum_ocadd #(.W(W)) u_add (
            .a_i (acc_r),
            .b_i (word_r),
            .y_o (nxt_o)
         );
      end
   endgenerate

endmodule

// File: rtl/rotsum_accum.sv
module rotsum_accum #(
   parameter int               W     = 16,
   parameter rotsum_pkg::order_e ORDER = rotsum_pkg::ORD_ADD_ROT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  rotsum_pkg::ctl_t    ctl_i,
   input  logic [W-1:0]        word_i,
   output logic [W-1:0]        nxt_o,
   output logic                fire_o
);

   logic [W-1:0] acc_q;
   logic [W-1:0] base;
   logic         take;

   assign take   = ctl_i.vld & ~ctl_i.clr;
   assign fire_o = take & ctl_i.eop;
   assign base   = ctl_i.sop ? '0 : acc_q;

   rotsum_step #(.W(W), .ORDER(ORDER)) u_step (
      .acc_i  (base),
      .word_i (word_i),
      .nxt_o  (nxt_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (ctl_i.clr) begin
         acc_q <= '0;
      end else if (take) begin
         acc_q <= ctl_i.eop ? '0 : nxt_o;
      end
   end

endmodule

// File: rtl/rotsum_result.sv
module rotsum_result #(
   parameter int W            = 16,
   parameter bit FOLD_ALLONES = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire_i,
   input  logic [W-1:0] nxt_i,
   input  logic [W-1:0] expect_i,
   output logic [W-1:0] sum_o,
   output logic         done_o,
   output logic         match_o,
   output logic         check_en_o
);

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   logic [W-1:0] final_sum;
   logic         en_d;

   generate
      if (FOLD_ALLONES) begin : g_fold
         assign final_sum = (nxt_i == ALL_ONES) ? '0 : nxt_i;
      end else begin : g_raw
         assign final_sum = nxt_i;
      end
   endgenerate

   assign en_d = (expect_i != ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o      <= '0;
         done_o     <= 1'b0;
         match_o    <= 1'b0;
         check_en_o <= 1'b0;
      end else begin
         done_o <= fire_i;
         if (fire_i) begin
            sum_o      <= final_sum;
            check_en_o <= en_d;
            match_o    <= en_d && (final_sum == expect_i);
         end
      end
   end

endmodule

// File: rtl/rotsum_engine.sv
module rotsum_engine #(
   parameter int               W            = 16,
   parameter rotsum_pkg::order_e ORDER        = rotsum_pkg::ORD_ADD_ROT,
   parameter bit               FOLD_ALLONES = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         word_vld_i,
   input  logic         word_sop_i,
   input  logic         word_eop_i,
   input  logic [W-1:0] word_i,
   input  logic [W-1:0] expect_i,
   output logic [W-1:0] sum_o,
   output logic         done_o,
   output logic         match_o,
   output logic         check_en_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("rotsum_engine: W must be at least 2 for a rotation");
      end
      if (W > 64) begin : g_wide_width
         $error("rotsum_engine: W above 64 is not supported");
      end
   endgenerate

   rotsum_pkg::ctl_t ctl;
   logic [W-1:0]     nxt;
   logic             fire;

   assign ctl.clr = clr_i;
   assign ctl.vld = word_vld_i;
   assign ctl.sop = word_sop_i;
   assign ctl.eop = word_eop_i;

   rotsum_accum #(.W(W), .ORDER(ORDER)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_i  (ctl),
      .word_i (word_i),
      .nxt_o  (nxt),
      .fire_o (fire)
   );

   rotsum_result #(.W(W), .FOLD_ALLONES(FOLD_ALLONES)) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire),
      .nxt_i      (nxt),
      .expect_i   (expect_i),
      .sum_o      (sum_o),
      .done_o     (done_o),
      .match_o    (match_o),
      .check_en_o (check_en_o)
   );

endmodule

// File: rtl/rotsum_chk.sv
module rotsum_chk #(
   parameter int W            = 16,
   parameter bit FOLD_ALLONES = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr_i,
   input logic         word_vld_i,
   input logic         word_eop_i,
   input logic [W-1:0] expect_i,
   input logic [W-1:0] sum_o,
   input logic         done_o,
   input logic         match_o,
   input logic         check_en_o
);

   AST_DONE_FOLLOWS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld_i && word_eop_i && !clr_i) |=> done_o); // R8

   AST_DONE_NEEDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(word_vld_i && word_eop_i && !clr_i)); // R8

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(sum_o) && $stable(match_o) && $stable(check_en_o))); // R8

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !done_o); // R9

   AST_NO_ALLONES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && FOLD_ALLONES) |-> (sum_o != {W{1'b1}})); // R5

   AST_SENTINEL_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (check_en_o == ($past(expect_i) != {W{1'b1}}))); // R6

   AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> check_en_o); // R7

   AST_MATCH_MEANS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && match_o) |-> (sum_o == $past(expect_i))); // R7

endmodule

bind rotsum_engine rotsum_chk #(.W(W), .FOLD_ALLONES(FOLD_ALLONES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_i      (clr_i),
   .word_vld_i (word_vld_i),
   .word_eop_i (word_eop_i),
   .expect_i   (expect_i),
   .sum_o      (sum_o),
   .done_o     (done_o),
   .match_o    (match_o),
   .check_en_o (check_en_o)
);

// File: tb/rotsum_engine_tb.sv
`timescale 1ns/1ps
module rotsum_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0, vld = 1'b0, sop = 1'b0, eop = 1'b0;
   logic [15:0] word = '0, expv = '0;

   logic [15:0] sum_a, sum_b;
   logic        done_a, done_b, match_a, match_b, en_a, en_b;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 1'b0;
   string cur_req = "R11";

   always #2.5 clk = ~clk;

   rotsum_engine #(.W(16), .ORDER(rotsum_pkg::ORD_ADD_ROT), .FOLD_ALLONES(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .word_vld_i(vld), .word_sop_i(sop),
      .word_eop_i(eop), .word_i(word), .expect_i(expv), .sum_o(sum_a),
      .done_o(done_a), .match_o(match_a), .check_en_o(en_a));

   rotsum_engine #(.W(16), .ORDER(rotsum_pkg::ORD_ROT_ADD), .FOLD_ALLONES(1'b0)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .word_vld_i(vld), .word_sop_i(sop),
      .word_eop_i(eop), .word_i(word), .expect_i(expv), .sum_o(sum_b),
      .done_o(done_b), .match_o(match_b), .check_en_o(en_b));

   // ---------------- behavioural reference ----------------
   function automatic logic [15:0] ref_step(input logic [15:0] acc, input logic [15:0] w);
      int s;
      s = int'(acc) + int'(w);
      if (s > 65535) s = s - 65535;
      return 16'(((s << 1) | (s >> 15)) & 65535);
   endfunction

   logic [15:0] m_acc = '0;
   logic [15:0] m_sum_a = '0, m_sum_b = '0;
   logic        m_done = 1'b0, m_en = 1'b0, m_match_a = 1'b0, m_match_b = 1'b0;

   always @(posedge clk) begin
      logic [15:0] nx;
      if (!rst_n) begin
         m_acc = '0; m_sum_a = '0; m_sum_b = '0;
         m_done = 1'b0; m_en = 1'b0; m_match_a = 1'b0; m_match_b = 1'b0;
      end else begin
         m_done = 1'b0;
         if (clr) begin
            m_acc = '0;
         end else if (vld) begin
            nx = ref_step(sop ? 16'h0000 : m_acc, word);
            if (eop) begin
               m_done    = 1'b1;
               m_sum_b   = nx;
               m_sum_a   = (nx == 16'hFFFF) ? 16'h0000 : nx;
               m_en      = (expv != 16'hFFFF);
               m_match_a = m_en && (m_sum_a == expv);
               m_match_b = m_en && (m_sum_b == expv);
               m_acc     = '0;
            end else begin
               m_acc = nx;
            end
         end
      end
   end

   // compare both instances to the reference on every clock
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         n_checks += 2;
         if ({sum_a, done_a, match_a, en_a} !== {m_sum_a, m_done, m_match_a, m_en}) begin
            n_fail++;
            $display("FAIL %s u_dut: got sum=%h done=%b match=%b en=%b exp sum=%h done=%b match=%b en=%b",
                     cur_req, sum_a, done_a, match_a, en_a, m_sum_a, m_done, m_match_a, m_en);
         end
         if ({sum_b, done_b, match_b, en_b} !== {m_sum_b, m_done, m_match_b, m_en}) begin
            n_fail++;
            $display("FAIL %s (R4 ordering) u_dut_alt: got sum=%h done=%b match=%b en=%b exp sum=%h done=%b match=%b en=%b",
                     cur_req, sum_b, done_b, match_b, en_b, m_sum_b, m_done, m_match_b, m_en);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   task automatic put(input logic s, input logic e, input logic [15:0] w, input logic [15:0] x);
      @(negedge clk);
      clr = 1'b0; vld = 1'b1; sop = s; eop = e; word = w; expv = x;
   endtask

   task automatic idle(input logic [15:0] junk);
      @(negedge clk);
      clr = 1'b0; vld = 1'b0; sop = 1'b0; eop = 1'b0; word = junk;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 sum", 32'(sum_a), 32'h0);
      check("R11 flags", {29'b0, done_a, match_a, en_a}, 32'h0);
      rst_n = 1'b1;
      idle(16'h0);

      // R3: single word 0x0001 -> 0x0002
      cur_req = "R3";
      put(1, 1, 16'h0001, 16'h0002);
      idle(16'h0);
      check("R3 sum", 32'(sum_a), 32'h0002);
      check("R8 done pulse", 32'(done_a), 32'h1);
      check("R7 match", {30'b0, match_a, en_a}, 32'h3);
      idle(16'h0);
      check("R8 single pulse", 32'(done_a), 32'h0);

      // R2: end-around carry
      cur_req = "R2";
      put(1, 0, 16'h8000, 16'h0);
      put(0, 1, 16'hFFFF, 16'h1234);
      idle(16'h0);
      check("R2 sum", 32'(sum_a), 32'h0002);
      check("R7 mismatch", {30'b0, match_a, en_a}, 32'h1);
      check("R4 alt sum", 32'(sum_b), 32'h0002);

      // R5: all-ones folding (u_dut) vs raw (u_dut_alt)
      cur_req = "R5";
      put(1, 0, 16'h0001, 16'h0000);
      put(0, 1, 16'hFFFD, 16'h0000);
      idle(16'h0);
      check("R5 folded", 32'(sum_a), 32'h0000);
      check("R5 raw", 32'(sum_b), 32'hFFFF);
      check("R7 folded zero matches", 32'(match_a), 32'h1);

      // R6: sentinel disables checking
      cur_req = "R6";
      put(1, 1, 16'h7FFF, 16'hFFFF);
      idle(16'h0);
      check("R6 en low", {30'b0, en_a, match_a}, 32'h0);
      check("R6 alt raw all-ones not matched", {30'b0, en_b, match_b}, 32'h0);

      // R10: gaps with garbage words
      cur_req = "R10";
      put(1, 0, 16'h0001, 16'h0);
      idle(16'hDEAD);
      idle(16'hBEEF);
      put(0, 1, 16'h0000, 16'h0);
      idle(16'h0);
      check("R10 gaps ignored", 32'(sum_a), 32'h0004);
      repeat (3) idle(16'h5A5A);
      check("R8 result held", 32'(sum_a), 32'h0004);

      // R9: clear mid packet, word dropped; clear on eop suppresses done
      cur_req = "R9";
      put(1, 0, 16'h0100, 16'h0);
      @(negedge clk);
      clr = 1'b1; vld = 1'b1; sop = 1'b0; eop = 1'b0; word = 16'h7777;
      put(0, 1, 16'h0001, 16'h0002);
      idle(16'h0);
      check("R9 restart", 32'(sum_a), 32'h0002);
      put(1, 0, 16'h0003, 16'h0);
      @(negedge clk);
      clr = 1'b1; vld = 1'b1; sop = 1'b0; eop = 1'b1; word = 16'h1111;
      idle(16'h0);
      check("R9 no done on cleared eop", 32'(done_a), 32'h0);
      check("R9 result untouched", 32'(sum_a), 32'h0002);

      // R1: restart at sop mid stream, and zero start after eop
      cur_req = "R1";
      put(1, 0, 16'h4321, 16'h0);
      put(1, 1, 16'h0001, 16'h0);
      idle(16'h0);
      check("R1 sop restart", 32'(sum_a), 32'h0002);
      put(0, 1, 16'h0001, 16'h0);
      idle(16'h0);
      check("R1 zero after eop", 32'(sum_a), 32'h0002);

      // back-to-back packets and random streams (reference compares each clock)
      cur_req = "R8";
      put(1, 1, 16'h0010, 16'h0);
      put(1, 1, 16'h0020, 16'h0040);
      idle(16'h0);
      check("R8 back-to-back", {15'b0, done_a, sum_a}, {15'b0, 1'b1, 16'h0040});
      cur_req = "R4";
      for (int p = 0; p < 300; p++) begin
         int len;
         len = 1 + int'($urandom % 40);
         for (int i = 0; i < len; i++) begin
            if (($urandom % 5) == 0) idle(16'($urandom));
            put(i == 0, i == len - 1, 16'($urandom),
                (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom));
         end
         if (($urandom % 3) == 0) idle(16'h0);
      end
      idle(16'h0);
      idle(16'h0);
      finish_run();
   end

endmodule